// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned 16-bit operands and an incoming carry bit. It returns a 16-bit sum and the carry out of the top bit. The adder is purely combinational. It is meant to sit inside a datapath stage whose registers belong to the surrounding logic.

The operand width is cut into 4-bit slices. Each slice derives a generate term and a propagate term for every bit pair. It resolves all of its internal carries with flattened sum-of-products equations, so no carry ripples from bit to bit. Each slice also reports a single group propagate and a single group generate. A separate second-level carry unit consumes those group pairs together with the incoming carry. It produces the carries into the three upper slices and the final carry out, using the same flattened form one level up. The slice width and total width are parameters.

Top module: `cla16_adder`

## Requirements
- R1: For every input pattern, the value `{co, total}` equals `x + y + ci` computed as a 17-bit unsigned number.
- R2: When every bit pair differs (`x ^ y` all ones), the sum is `~ci` replicated in every bit and `co` equals `ci`, so an incoming carry travels the whole width.
- R3: A carry generated in the lowest slice (`x[3:0] + y[3:0] >= 16`) reaches bit 4, and reaches `co` when the upper bits of `x ^ y` are all ones.
- R4: The carry into each slice boundary (bits 4, 8 and 12) is set exactly when the lower part of the operands plus `ci` overflows that boundary; this is observable in the sum bits at positions 4, 8 and 12.
- R5: Inside every slice and inside the second-level unit, the group propagate and the group generate are never both high.
- R6: The carry out of each lookahead level equals its group generate OR (its group propagate AND its incoming carry).
- R7: The block holds no state. The outputs follow a change of the inputs without any clock edge, and all-zero inputs with `ci` = 0 give a zero sum and `co` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First addend |
| y | input | 16 | Second addend |
| ci | input | 1 | Incoming carry, added at bit 0 |
| total | output | 16 | Sum, modulo 2^16 |
| co | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that is born in one slice and must pass through every higher slice on group propagate alone. It is also the least likely case under random stimulus: it needs every upper bit pair to differ, which has probability 2^-12 or lower. Directed vectors produce this on purpose. Complementary operands combined with a set `ci` carry the input all the way to `co`. A generate in slice 0 placed under an all-propagate upper half does the same from inside the adder. Single-boundary vectors at bits 4, 8 and 12 test each second-level carry on its own.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned CLA_WIDTH   = 16;
  parameter int unsigned CLA_SLICE_W = 4;

  localparam int unsigned CLA_SLICES = CLA_WIDTH / CLA_SLICE_W;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         grp_p,
  output logic         grp_g
);
  // Flattened carries: c[i+1] = OR_j ( g[j] & p[j+1..i] ) | ( p[0..i] & cin )
  always_comb begin
    logic acc;
    logic term;
    carry[0] = cin;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prop[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k <= i; k++) term = term & prop[k];
      carry[i+1] = acc | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int k = j + 1; k < N; k++) term = term & prop[k];
      acc = acc | term;
    end
    grp_g = acc;
    grp_p = &prop;
  end

  always_comb begin
    assert_grp_exclusive_R5: assert (!(grp_p && grp_g))
      else $error("group propagate and generate both high");
    assert_carry_out_R6: assert (carry[N] == (grp_g | (grp_p & cin)))
      else $error("carry out disagrees with group terms");
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] s_out,
  output logic         gp_out,
  output logic         gg_out
);
  logic [W-1:0] g_bit;
  logic [W-1:0] p_bit;
  logic [W:0]   c_int;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bitpg
      assign g_bit[gi] = a_in[gi] & b_in[gi];
      assign p_bit[gi] = a_in[gi] ^ b_in[gi];
      assign s_out[gi] = p_bit[gi] ^ c_int[gi];
    end
  endgenerate

  cla_lookahead #(.N(W)) u_look (
    .gen   (g_bit),
    .prop  (p_bit),
    .cin   (c_in),
    .carry (c_int),
    .grp_p (gp_out),
    .grp_g (gg_out)
  );

  always_comb begin
    assert_slice_sum_R1: assert ({c_int[W], s_out} ==
        ({1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int unsigned NS = 4
) (
  input  logic [NS-1:0] grp_p,
  input  logic [NS-1:0] grp_g,
  input  logic          cin,
  output logic [NS:0]   slice_c
);
  logic top_p;
  logic top_g;

  cla_lookahead #(.N(NS)) u_look2 (
    .gen   (grp_g),
    .prop  (grp_p),
    .cin   (cin),
    .carry (slice_c),
    .grp_p (top_p),
    .grp_g (top_g)
  );

  genvar k;
  generate
    for (k = 0; k < NS; k++) begin : g_chk
      always_comb begin
        assert_boundary_carry_R4: assert (slice_c[k+1] ==
            (grp_g[k] | (grp_p[k] & slice_c[k])))
          else $error("boundary carry %0d inconsistent", k + 1);
      end
    end
  endgenerate

  always_comb begin
    assert_top_terms_R6: assert (slice_c[NS] == (top_g | (top_p & cin)))
      else $error("second level carry out inconsistent");
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned WIDTH   = cla_pkg::CLA_WIDTH,
  parameter int unsigned SLICE_W = cla_pkg::CLA_SLICE_W
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             ci,
  output logic [WIDTH-1:0] total,
  output logic             co
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  logic [NSLICE-1:0] gp;
  logic [NSLICE-1:0] gg;
  logic [NSLICE:0]   sc;

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_slice
      cla_slice #(.W(SLICE_W)) u_slice (
        .a_in   (x[s*SLICE_W +: SLICE_W]),
        .b_in   (y[s*SLICE_W +: SLICE_W]),
        .c_in   (sc[s]),
        .s_out  (total[s*SLICE_W +: SLICE_W]),
        .gp_out (gp[s]),
        .gg_out (gg[s])
      );
    end
  endgenerate

  cla_carry_unit #(.NS(NSLICE)) u_carry (
    .grp_p   (gp),
    .grp_g   (gg),
    .cin     (ci),
    .slice_c (sc)
  );

  assign co = sc[NSLICE];

  always_comb begin
    assert_full_sum_R1: assert ({co, total} ==
        ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci}))
      else $error("adder result mismatch");
    assert_full_prop_R2: assert (!(((x ^ y) == {WIDTH{1'b1}}) && (co != ci)))
      else $error("full propagate carry lost");
  end
endmodule

// File: tb/tb_cla16_adder.sv
module tb_cla16_adder;
  logic        clk = 1'b0;
  logic [15:0] x, y;
  logic        ci;
  logic [15:0] total;
  logic        co;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cla16_adder dut (.x(x), .y(y), .ci(ci), .total(total), .co(co));

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(input string tag, input logic [15:0] a,
                                 input logic [15:0] b, input logic c);
    logic [16:0] exp;
    @(negedge clk);
    x = a; y = b; ci = c;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    check(tag, {co, total}, exp);
  endtask

  task automatic t_zero;  // R7
    apply_and_check("R7 zero inputs", 16'h0000, 16'h0000, 1'b0);
    check("R7 zero literal", {co, total}, 17'h0);
  endtask

  task automatic t_no_clock;  // R7: outputs follow inputs between edges
    @(posedge clk);
    #3;
    x = 16'h1234; y = 16'h1111; ci = 1'b0;
    #1;
    check("R7 update without edge", {co, total}, 17'h02345);
    x = 16'h0001;
    #1;
    check("R7 second update without edge", {co, total}, 17'h01112);
  endtask

  task automatic t_full_propagate;  // R2
    apply_and_check("R2 ones plus one", 16'hFFFF, 16'h0000, 1'b1);
    check("R2 wrap literal", {co, total}, 17'h10000);
    apply_and_check("R2 alternating ci1", 16'hAAAA, 16'h5555, 1'b1);
    apply_and_check("R2 alternating ci0", 16'h5555, 16'hAAAA, 1'b0);
    check("R2 alternating literal", {co, total}, 17'h0FFFF);
    apply_and_check("R2 ones plus one via y", 16'hFFFF, 16'h0001, 1'b0);
  endtask

  task automatic t_generate_low;  // R3
    apply_and_check("R3 gen to bit4", 16'h000F, 16'h0001, 1'b0);
    check("R3 bit4 literal", {co, total}, 17'h00010);
    apply_and_check("R3 gen to co", 16'hFFF8, 16'h0008, 1'b0);
    check("R3 co literal", {co, total}, 17'h10000);
  endtask

  task automatic t_boundaries;  // R4
    apply_and_check("R4 boundary 8", 16'h00FF, 16'h0000, 1'b1);
    check("R4 boundary 8 literal", {co, total}, 17'h00100);
    apply_and_check("R4 boundary 12", 16'h0F00, 16'h0100, 1'b0);
    check("R4 boundary 12 literal", {co, total}, 17'h01000);
    apply_and_check("R4 top generate", 16'h8000, 16'h8000, 1'b0);
    check("R4 top generate literal", {co, total}, 17'h10000);
    apply_and_check("R4 mid no carry", 16'h0EFF, 16'h0100, 1'b0);
  endtask

  task automatic t_random;  // R1
    for (int i = 0; i < 400; i++) begin
      apply_and_check("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end
    apply_and_check("R1 max plus max", 16'hFFFF, 16'hFFFF, 1'b1);
    check("R1 max literal", {co, total}, 17'h1FFFF);
  endtask

  task automatic t_group_exclusive;  // R5, R6 through port behaviour
    apply_and_check("R5 slice all generate", 16'h000F, 16'h000F, 1'b0);
    apply_and_check("R6 slice prop and gen mix", 16'h0F0F, 16'h00F1, 1'b1);
  endtask

  initial begin
    x = '0; y = '0; ci = 1'b0;
    t_zero();
    t_no_clock();
    t_full_propagate();
    t_generate_low();
    t_boundaries();
    t_group_exclusive();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule